// File: doc/BRIEF.md
# Power-Up and Self-Calibration Sequencer

This block decides when an A/D converter calibrates itself and keeps conversions out of the way while it does. After reset or a power-failure indication, it first holds off for a long settling interval. Once that interval ends, it runs a fixed-length calibration window, then starts one ordinary conversion on its own, and finally returns to idle. The settling hold-off lets supplies and the reference settle before the coefficients are measured.

Calibration can also be requested at any time. Two sources can request it: the rising edge of an active-low calibrate pin, which is first passed through a two-flop synchroniser, and a control-register write with the calibrate bit set. The calibrate bit does not stay set, so each write carries one request. A request takes over any conversion in progress. A request during calibration starts the window again from the beginning. A request during the settling hold-off folds into the calibration already pending.

Convert commands are honoured only when the sequencer is idle. The sequencer drives an active-low busy line, a calibration-active flag and a two-bit phase code. It also gives one-cycle start strobes for the coefficient engine and the conversion engine. Those engines are outside this block. There is no streaming data path: every pin is a plain control or status signal.

Top module: `cal_sched`

## Requirements
- R1: While reset is asserted, and for exactly WAIT_CYCLES clock edges after it is released, `phase` is 1 (power wait), `busy_n` is 0 and `cal_active` is 0. At the next edge, calibration begins.
- R2: Each calibration run has `phase` = 2 and `cal_active` = 1, and lasts exactly CAL_CYCLES clocks. `cal_kick` is high only in the first cycle of each run.
- R3: When a calibration run ends, the block enters `phase` = 3 (convert) for exactly CONV_CYCLES clocks, with `conv_kick` high in the first cycle. It then enters `phase` = 0 (idle) with `busy_n` = 1.
- R4: A `conv_req` pulse while idle starts a conversion at the next clock edge (`phase` 3, `conv_kick` high).
- R5: A write (`cfg_we` = 1) with bit 1 of `cfg_wdata` set starts calibration at the next edge. A write with bit 1 clear has no effect.
- R6: A low-to-high transition of `cal_n` starts calibration. The phase changes at the second clock edge after the first edge that samples the pin high. A falling edge, or holding the pin low, has no effect.
- R7: A calibration request during a conversion aborts it and starts calibration.
- R8: `conv_req` is ignored in the power-wait, calibrate and convert phases.
- R9: A calibration request during power wait neither restarts nor shortens the wait. Calibration still begins WAIT_CYCLES edges after the wait began.
- R10: A calibration request during calibration restarts the run. A fresh `cal_kick` is issued and a full CAL_CYCLES window follows.
- R11: `pwr_fail` high at a clock edge forces power wait from any phase. The wait counts from the last edge at which `pwr_fail` is high.
- R12: `busy_n` is 1 only in the idle phase, and `cal_active` is 1 only in the calibrate phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail | input | 1 | Power-failure indication, synchronous, active high |
| cal_n | input | 1 | Asynchronous active-low calibrate pin; its rising edge requests calibration |
| cfg_we | input | 1 | Control-register write strobe |
| cfg_wdata | input | CFG_W | Control-register write data; bit 1 requests calibration |
| conv_req | input | 1 | Convert command pulse |
| busy_n | output | 1 | Low whenever the sequencer is not idle |
| cal_active | output | 1 | High during calibration |
| cal_kick | output | 1 | One-cycle strobe on the first cycle of each calibration run |
| conv_kick | output | 1 | One-cycle strobe on the first cycle of each conversion |
| phase | output | 2 | 0 idle, 1 power wait, 2 calibrate, 3 convert |

## Verification
The bench measures each phase boundary to the exact edge. A counter that is off by one would move the calibrate or convert strobe one cycle early or late. It checks that a write with bit 1 clear does nothing, and that a held-low calibrate pin does nothing until it is released. A design that acted on the falling edge, or that skipped the synchroniser delay, would start calibration early. It sends requests while calibration is running and during power wait. A design that failed to restart the window would drop the second `cal_kick`. A design that restarted the wait would calibrate late. It also sends convert commands during calibration and during power wait, and a wrongly gated command would show up as a stray `conv_kick`.

// File: rtl/cal_sched_pkg.sv
package cal_sched_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PWAIT = 2'd1,
    PH_CAL   = 2'd2,
    PH_CONV  = 2'd3
  } phase_e;
endpackage

// File: rtl/cal_pin_edge.sv
// Synchronises an asynchronous active-low pin and flags its rising edge.
module cal_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= pin_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[STAGES-1];

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cal_down_cnt.sv
// Loadable down-counter that parks at zero.
module cal_down_cnt #(
  parameter int          W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               cnt_q <= RST_VAL;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/cal_sched.sv
module cal_sched
  import cal_sched_pkg::*;
#(
  parameter int WAIT_CYCLES = 42425,
  parameter int CAL_CYCLES  = 168,
  parameter int CONV_CYCLES = 17,
  parameter int CFG_W       = 8,
  parameter int CAL_BIT     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_fail,
  input  logic             cal_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             conv_req,
  output logic             busy_n,
  output logic             cal_active,
  output logic             cal_kick,
  output logic             conv_kick,
  output logic [1:0]       phase
);
  localparam int MAX_LEN = (WAIT_CYCLES > CAL_CYCLES)
                         ? ((WAIT_CYCLES > CONV_CYCLES) ? WAIT_CYCLES : CONV_CYCLES)
                         : ((CAL_CYCLES > CONV_CYCLES) ? CAL_CYCLES : CONV_CYCLES);
  localparam int CW = $clog2(MAX_LEN + 1);
  localparam logic [CW-1:0] WAIT_LD = CW'(WAIT_CYCLES - 1);
  localparam logic [CW-1:0] CAL_LD  = CW'(CAL_CYCLES - 1);
  localparam logic [CW-1:0] CONV_LD = CW'(CONV_CYCLES - 1);

  phase_e          ph_q, ph_d;
  logic            pin_rise, cal_req, cnt_zero, load;
  logic [CW-1:0]   load_val;
  logic            cal_kick_q, conv_kick_q;

  cal_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_n(cal_n), .rise(pin_rise)
  );

  cal_down_cnt #(.W(CW), .RST_VAL(WAIT_LD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .zero(cnt_zero)
  );

  // A register write carries a one-shot request; nothing is stored.
  assign cal_req = pin_rise | (cfg_we & cfg_wdata[CAL_BIT]);

  always_comb begin
    ph_d     = ph_q;
    load     = 1'b0;
    load_val = '0;
    if (pwr_fail) begin
      ph_d = PH_PWAIT; load = 1'b1; load_val = WAIT_LD;
    end else begin
      unique case (ph_q)
        PH_PWAIT: begin
          // requests here merge into the pending calibration
          if (cnt_zero) begin
            ph_d = PH_CAL; load = 1'b1; load_val = CAL_LD;
          end
        end
        PH_CAL: begin
          if (cal_req) begin
            ph_d = PH_CAL; load = 1'b1; load_val = CAL_LD;
          end else if (cnt_zero) begin
            ph_d = PH_CONV; load = 1'b1; load_val = CONV_LD;
          end
        end
        PH_CONV: begin
          if (cal_req) begin
            ph_d = PH_CAL; load = 1'b1; load_val = CAL_LD;
          end else if (cnt_zero) begin
            ph_d = PH_IDLE;
          end
        end
        default: begin
          if (cal_req) begin
            ph_d = PH_CAL; load = 1'b1; load_val = CAL_LD;
          end else if (conv_req) begin
            ph_d = PH_CONV; load = 1'b1; load_val = CONV_LD;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph_q        <= PH_PWAIT;
      cal_kick_q  <= 1'b0;
      conv_kick_q <= 1'b0;
    end else begin
      ph_q        <= ph_d;
      cal_kick_q  <= load & (ph_d == PH_CAL);
      conv_kick_q <= load & (ph_d == PH_CONV);
    end

  assign phase      = ph_q;
  assign busy_n     = (ph_q == PH_IDLE);
  assign cal_active = (ph_q == PH_CAL);
  assign cal_kick   = cal_kick_q;
  assign conv_kick  = conv_kick_q;
endmodule

// File: rtl/cal_sched_chk.sv
module cal_sched_chk #(
  parameter int CAL_CYCLES = 168,
  parameter int CFG_W      = 8,
  parameter int CAL_BIT    = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_fail,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic             busy_n,
  input logic             cal_active,
  input logic             cal_kick,
  input logic             conv_kick,
  input logic [1:0]       phase
);
  localparam int LW = $clog2(CAL_CYCLES + 1);
  logic [LW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              run_len <= '0;
    else if (phase == 2'd2)  run_len <= cal_kick ? LW'(1) : run_len + 1'b1;
    else                     run_len <= '0;

  a_r2_kick_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
    cal_kick |-> (phase == 2'd2 && cal_active && !busy_n));

  a_r2_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && !cal_kick) |-> (run_len < LW'(CAL_CYCLES)));

  a_r2_run_full: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && $past(phase) == 2'd2) |-> ($past(run_len) == LW'(CAL_CYCLES - 1)));

  a_r3_conv_after_cal: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && $past(phase) == 2'd2) |-> conv_kick);

  a_r3_idle_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 && $past(phase) == 2'd3) |-> (busy_n && !cal_active && !conv_kick));

  a_r5_cfg_starts_cal: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[CAL_BIT] && !pwr_fail && phase != 2'd1)
      |=> (phase == 2'd2 && cal_kick));

  a_r8_conv_origin: assert property (@(posedge clk) disable iff (!rst_n)
    conv_kick |-> ($past(phase) == 2'd0 || $past(phase) == 2'd2));

  a_r11_pfail_wait: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (phase == 2'd1 && !busy_n && !cal_active));
endmodule

bind cal_sched cal_sched_chk #(
  .CAL_CYCLES(CAL_CYCLES), .CFG_W(CFG_W), .CAL_BIT(CAL_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .cfg_we(cfg_we),
  .cfg_wdata(cfg_wdata), .busy_n(busy_n), .cal_active(cal_active),
  .cal_kick(cal_kick), .conv_kick(conv_kick), .phase(phase)
);

// File: tb/cal_sched_test.sv
module cal_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_C = 42425;
  localparam int CAL_C  = 168;
  localparam int CONV_C = 17;

  localparam logic [2:0] OP_NOP = 3'd0, OP_CONV = 3'd1, OP_CFG = 3'd2,
                         OP_PIN = 3'd3, OP_PFAIL = 3'd4, OP_CFGX = 3'd5;

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic [15:0] n;
    logic [1:0]  ph;
    logic        bn;
    logic        ca;
    logic        ck;
    logic        vk;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{4'd4,  OP_CONV,  16'd0,          2'd3, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 start
    '{4'd4,  OP_NOP,   16'(CONV_C-2),  2'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 last cycle
    '{4'd3,  OP_NOP,   16'd0,          2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 back to idle
    '{4'd5,  OP_CFGX,  16'd0,          2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 bit 1 clear
    '{4'd5,  OP_CFG,   16'd0,          2'd2, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 write starts cal
    '{4'd8,  OP_CONV,  16'd0,          2'd2, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 conv ignored
    '{4'd2,  OP_NOP,   16'(CAL_C-3),   2'd2, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 last cal cycle
    '{4'd3,  OP_NOP,   16'd0,          2'd3, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 appended conv
    '{4'd8,  OP_CONV,  16'd4,          2'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 conv during conv
    '{4'd7,  OP_CFG,   16'd0,          2'd2, 1'b0, 1'b1, 1'b1, 1'b0}, // R7 preempt
    '{4'd2,  OP_NOP,   16'd50,         2'd2, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 mid run
    '{4'd10, OP_PIN,   16'd3,          2'd2, 1'b0, 1'b1, 1'b1, 1'b0}, // R10 restart
    '{4'd10, OP_NOP,   16'(CAL_C-2),   2'd2, 1'b0, 1'b1, 1'b0, 1'b0}, // R10 full window
    '{4'd10, OP_NOP,   16'd0,          2'd3, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 then conv
    '{4'd3,  OP_NOP,   16'(CONV_C-2),  2'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 conv length
    '{4'd12, OP_NOP,   16'd0,          2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R12 idle flags
    '{4'd6,  OP_PIN,   16'd3,          2'd2, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 pin edge
    '{4'd11, OP_PFAIL, 16'd0,          2'd1, 1'b0, 1'b0, 1'b0, 1'b0}  // R11 power fail
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_fail = 1'b0;
  logic       cal_n = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       conv_req = 1'b0;
  logic       busy_n, cal_active, cal_kick, conv_kick;
  logic [1:0] phase;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_sched #(.WAIT_CYCLES(WAIT_C), .CAL_CYCLES(CAL_C), .CONV_CYCLES(CONV_C)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .cal_n(cal_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .conv_req(conv_req),
    .busy_n(busy_n), .cal_active(cal_active), .cal_kick(cal_kick),
    .conv_kick(conv_kick), .phase(phase)
  );

  task automatic check(input int req, input logic [1:0] ph, input logic bn,
                       input logic ca, input logic ck, input logic vk);
    logic [5:0] got, exp;
    got = {phase, busy_n, cal_active, cal_kick, conv_kick};
    exp = {ph, bn, ca, ck, vk};
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d: {phase,busy_n,cal_active,cal_kick,conv_kick} got %b expected %b",
               req, got, exp);
    end
  endtask

  // Called at a negedge: drive for one cycle, then wait n more negedges.
  task automatic step(input logic [2:0] op, input int n);
    case (op)
      OP_CONV:  conv_req = 1'b1;
      OP_CFG:   begin cfg_we = 1'b1; cfg_wdata = 8'h02; end
      OP_CFGX:  begin cfg_we = 1'b1; cfg_wdata = 8'hFD; end
      OP_PIN:   cal_n = 1'b0;
      OP_PFAIL: pwr_fail = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    conv_req = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; cal_n = 1'b1; pwr_fail = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);          // R1 during reset
    rst_n = 1'b1;
    repeat (WAIT_C-1) @(negedge clk);
    check(1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);          // R1 last wait cycle
    @(negedge clk);
    check(1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);          // R1 calibration begins
    repeat (CAL_C-1) @(negedge clk);
    check(2, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0);          // R2 exact length
    @(negedge clk);
    check(3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);          // R3 auto conversion
    repeat (CONV_C-1) @(negedge clk);
    check(3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);          // R3 idle

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].op, int'(TBL[i].n));
      check(int'(TBL[i].req), TBL[i].ph, TBL[i].bn, TBL[i].ca, TBL[i].ck, TBL[i].vk);
    end

    // R9: request during power wait merges (wait began at last table row)
    step(OP_CFG, 99);
    check(9, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(OP_CONV, 0);
    check(8, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);          // R8 conv in wait
    repeat (WAIT_C-1-101) @(negedge clk);
    check(9, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(9, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);          // R9 on original schedule

    // R11: held power-fail keeps restarting the wait
    pwr_fail = 1'b1;
    repeat (5) @(negedge clk);
    check(11, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    pwr_fail = 1'b0;
    repeat (WAIT_C-1) @(negedge clk);
    check(11, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(11, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
    repeat (CAL_C+CONV_C) @(negedge clk);
    check(12, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);

    // R6: held-low pin does nothing until released
    cal_n = 1'b0;
    repeat (10) @(negedge clk);
    check(6, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    cal_n = 1'b1;
    repeat (2) @(negedge clk);
    check(6, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(6, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);

    // R1: reset during calibration returns to power wait
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (195000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule